// File: doc/BRIEF.md
# Byte-Multiplexed Tri-State Result Port

This block places a 12-bit conversion result onto an 8-bit data bus as two bytes. The bus is modelled as a data vector with a per-bit output enable, which stands in for tri-state drivers. A read/convert line and the busy status from the conversion sequencer decide when the bus is driven. A byte-select address bit picks which half of the result is shown: the upper eight bits, or the lower four bits padded with four zeros.

The enable comes from a three-state machine clocked with the system clock. In `PORT_FLOAT` the bus is released. If read/convert rises while busy is high, the machine goes to `PORT_ARMED`, where the bus stays released until the conversion ends. `PORT_DRIVE` drives the bus. The transitions are:
- FLOAT→DRIVE on read high with busy low.
- FLOAT→ARMED on read high with busy high.
- ARMED→DRIVE when busy falls with read still high.
- ARMED→FLOAT and DRIVE→FLOAT when read falls.
- DRIVE→ARMED when busy rises with read still high.

Byte selection is combinational. Changing the byte select therefore switches the byte in the same cycle and never releases the bus.

Top module: `byte_result_port`

## Requirements
- R1: While reset is held, every output-enable bit is 0 and the data bus reads 0.
- R2: If busy is 1 at a rising clock edge, all output-enable bits are 0 after that edge.
- R3: If read/convert is 1 and busy is 0 at a rising clock edge, all output-enable bits are 1 after that edge.
- R4: If read/convert goes high while busy is 1, the bus stays released for as long as busy stays 1. It is enabled after the first edge at which busy is 0 and read/convert is still 1, with no new read edge needed.
- R5: If read/convert is 0 at a rising clock edge, all output-enable bits are 0 after that edge.
- R6: While enabled with byte select 0, data equals result bits 11 down to 4.
- R7: While enabled with byte select 1, data bits 7..4 equal result bits 3..0 and data bits 3..0 are 0.
- R8: A change of byte select while enabled changes the data within the same cycle and leaves the output enable at all ones.
- R9: While the output enable is 0, the data bus reads 0.
- R10: The output-enable bits are always all equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| result | input | 12 | Conversion result from the sequencer |
| busy | input | 1 | High while a conversion is in progress |
| rd_cvt | input | 1 | Read/convert line, high requests a read |
| byte_sel | input | 1 | 0 selects the upper byte, 1 selects the low nibble with zero padding |
| bus_data | output | 8 | Data bus value, 0 while released |
| bus_oe | output | 8 | Per-bit output enable |

## Verification
The output enable is due one rising edge after the read/convert and busy values that cause it. The bench therefore drives those inputs on a falling edge and checks the enable at the next falling edge, after exactly one rising edge. Data depends combinationally on byte select and result, so it is checked in the same cycle as a change, 1 ns after the input moves and before any rising edge. The sweep covers every pair of consecutive (read, busy, select) settings for a set of result values.

// File: rtl/byte_port_pkg.sv
package byte_port_pkg;

    typedef enum logic [1:0] {
        PORT_FLOAT = 2'd0,
        PORT_ARMED = 2'd1,
        PORT_DRIVE = 2'd2
    } port_state_e;

endpackage

// File: rtl/rport_enable_fsm.sv
module rport_enable_fsm
    import byte_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cvt,
    input  logic busy,
    output logic drive_en
);

    port_state_e state_q;
    port_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PORT_FLOAT;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PORT_FLOAT: begin
                if (rd_cvt && !busy) begin
                    state_d = PORT_DRIVE;
                end else if (rd_cvt && busy) begin
                    state_d = PORT_ARMED;
                end
            end
            PORT_ARMED: begin
                if (!rd_cvt) begin
                    state_d = PORT_FLOAT;
                end else if (!busy) begin
                    state_d = PORT_DRIVE;
                end
            end
            PORT_DRIVE: begin
                if (!rd_cvt) begin
                    state_d = PORT_FLOAT;
                end else if (busy) begin
                    state_d = PORT_ARMED;
                end
            end
            default: state_d = PORT_FLOAT;
        endcase
    end

    // output logic
    always_comb begin
        drive_en = (state_q == PORT_DRIVE);
    end

    assert_busy_floats_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !drive_en);

    assert_read_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cvt && !busy) |=> drive_en);

    assert_armed_autodrive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PORT_ARMED && rd_cvt && !busy) |=> drive_en);

    assert_no_read_floats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_cvt |=> !drive_en);

endmodule

// File: rtl/rport_byte_mux.sv
module rport_byte_mux #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] result,
    input  logic             byte_sel,
    input  logic             drive_en,
    output logic [BUS_W-1:0] data
);

    localparam int LOW_W = RES_W - BUS_W;
    localparam int PAD_W = BUS_W - LOW_W;

    logic [BUS_W-1:0] hi_byte;
    logic [BUS_W-1:0] lo_byte;

    assign hi_byte = result[RES_W-1 -: BUS_W];
    assign lo_byte = {result[LOW_W-1:0], {PAD_W{1'b0}}};

    for (genvar b = 0; b < BUS_W; b++) begin : g_bit
        assign data[b] = drive_en & (byte_sel ? lo_byte[b] : hi_byte[b]);
    end

endmodule

// File: rtl/rport_oe_fan.sv
module rport_oe_fan #(
    parameter int BUS_W = 8
) (
    input  logic             drive_en,
    output logic [BUS_W-1:0] oe
);

    for (genvar b = 0; b < BUS_W; b++) begin : g_oe
        assign oe[b] = drive_en;
    end

endmodule

// File: rtl/byte_result_port.sv
module byte_result_port #(
    parameter int RES_W = 12,
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] result,
    input  logic             busy,
    input  logic             rd_cvt,
    input  logic             byte_sel,
    output logic [BUS_W-1:0] bus_data,
    output logic [BUS_W-1:0] bus_oe
);

    logic drive_en;

    rport_enable_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_cvt   (rd_cvt),
        .busy     (busy),
        .drive_en (drive_en)
    );

    rport_byte_mux #(.RES_W(RES_W), .BUS_W(BUS_W)) u_mux (
        .result   (result),
        .byte_sel (byte_sel),
        .drive_en (drive_en),
        .data     (bus_data)
    );

    rport_oe_fan #(.BUS_W(BUS_W)) u_fan (
        .drive_en (drive_en),
        .oe       (bus_oe)
    );

    assert_sel_keeps_oe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cvt && !busy && bus_oe[0]) |=> bus_oe[0]);

endmodule

// File: tb/tb_byte_result_port.sv
`timescale 1ns/1ps
module tb_byte_result_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] result = '0;
    logic        busy = 1'b0;
    logic        rd_cvt = 1'b0;
    logic        byte_sel = 1'b0;
    logic [7:0]  bus_data;
    logic [7:0]  bus_oe;

    int checks = 0;
    int failures = 0;
    bit exp_en = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_result_port dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .result   (result),
        .busy     (busy),
        .rd_cvt   (rd_cvt),
        .byte_sel (byte_sel),
        .bus_data (bus_data),
        .bus_oe   (bus_oe)
    );

    function automatic int exp_data(int res, bit sel, bit en);
        if (!en) return 0;
        if (sel) return (res % 16) * 16;
        return res / 16;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(string tag);
        check({tag, " oe (R2 R3 R5 R10)"}, bus_oe, exp_en ? 255 : 0);
        check({tag, " data (R6 R7 R9)"}, bus_data, exp_data(result, byte_sel, exp_en));
    endtask

    // drive on falling edge, check after one rising edge at next falling edge
    task automatic step(bit rd, bit b, bit s);
        rd_cvt = rd;
        busy = b;
        byte_sel = s;
        exp_en = rd & !b;
        @(posedge clk);
        @(negedge clk);
        check_outputs("step");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 oe in reset", bus_oe, 0);
        check("R1 data in reset", bus_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 directed: read raised during conversion
        result = 12'hA5C;
        step(1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 1'b1, 1'b0);
            check("R4 stays floating while busy", bus_oe, 0);
        end
        step(1'b1, 1'b0, 1'b0);
        check("R4 auto enable after busy falls", bus_oe, 255);
        check("R4 high byte", bus_data, 8'hA5);

        // R8: byte select change while driving
        byte_sel = 1'b1;
        #1;
        check("R8 oe held on select change", bus_oe, 255);
        check("R8 low byte same cycle", bus_data, 8'hC0);
        byte_sel = 1'b0;
        #1;
        check("R8 back to high byte", bus_data, 8'hA5);
        @(negedge clk);

        // sweep of consecutive setting pairs over several results
        for (int k = 0; k < 6; k++) begin
            result = 12'((k * 1237 + 291) % 4096);
            for (int p = 0; p < 8; p++) begin
                for (int c = 0; c < 8; c++) begin
                    step(p[2], p[1], p[0]);
                    step(c[2], c[1], c[0]);
                    byte_sel = ~byte_sel;
                    #1;
                    check_outputs("R8 select flip");
                    @(negedge clk);
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule